// File: doc/BRIEF.md
# Power-of-Two Output Clock Divider

This block takes a fast source clock, divides it by 1, 2, 4 or 8 according to a two-bit code, and gates the result with an active-high enable so that the output never carries a shortened pulse. A bypass select picks the source: the normal oscillator clock, or a slow external test clock used for board-level debug. Every register in the block runs on the selected source clock, which is the output clock domain.

The enable arrives asynchronously. It is carried through a two-flop synchroniser. A new enable value is then applied only at a point where the output is low. For ratios of two and above, the divided output is a register that is low for the first half of each period and high for the second half. For ratio one, the output is the source clock itself, passed through a gate that updates on the falling source edge. The divide code and the bypass select are configuration values that a separate block supplies. The bypass select is meant to change only while the block is held in reset or disabled.

Top module: `pow2_clk_div`

## Requirements
- R1: With divide code 00 and the enable in effect, the output equals the source clock: high during each source high phase and low during each source low phase.
- R2: Codes 01, 10 and 11 divide by 2, 4 and 8. Counting source rising edges from a counter restart, the output is low for the first half of each period and high for the second half, so the duty cycle is 50%.
- R3: The enable passes through two source-clock flops. For ratios of two and above, the synchronised value is applied only at the edge that starts a period's low half, so every high pulse has full width. While disabled, the output stays low.
- R4: With code 00, the synchronised enable is applied on the falling source edge, so the output never shows a partial high phase.
- R5: With bypass = 1 the external test clock is the divider input. With bypass = 0 the oscillator clock is.
- R6: A change of divide code drives the output low and restarts the counter from zero at the next source rising edge. The new ratio then begins with its low half.
- R7: A synchronous active-high reset clears the counter, the synchroniser and both gates, and holds the output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Normal oscillator source clock |
| test_clk | input | 1 | External slow test clock used in bypass |
| rst | input | 1 | Synchronous active-high reset, in the selected source domain |
| bypass | input | 1 | 1 selects test_clk as the source, 0 selects osc_clk |
| div_code | input | CODE_W (2) | Divide code: ratio is 2 to the power of the code |
| out_en | input | 1 | Active-high output enable, asynchronous |
| clk_out | output | 1 | Divided and gated output clock |

## Verification
A change of divide code shows at the output one source rising edge after it is presented. An enable change passes two synchroniser edges. After that, it waits for the next period boundary when the ratio is two or more, or for the next falling edge when the ratio is one. Reset takes effect at the first source edge while it is asserted. The bench keeps a behavioural model that advances on the same source edges. It compares the output 2 ns after every rising and every falling source edge, and drives all inputs 3 ns after a rising edge. Every sample therefore falls in a settled phase, after each of these latencies has already been counted in the model.

// File: rtl/pow2div_pkg.sv
package pow2div_pkg;

    // Number of source cycles in one output period for a given code.
    function automatic int unsigned period_of(input int unsigned code);
        return 32'd1 << code;
    endfunction

    // Counter width needed to count up to the largest period minus one.
    function automatic int unsigned count_width(input int unsigned code_w);
        return (32'd1 << code_w) - 32'd1;
    endfunction

    // Divider register state carried between the counter stage and output.
    typedef struct packed {
        logic gate;   // enable value currently applied
        logic pulse;  // registered divided clock
    } div_state_t;

endpackage

// File: rtl/clk_src_sel.sv
module clk_src_sel (
    input  logic norm_clk,
    input  logic alt_clk,
    input  logic use_alt,
    output logic src_clk
);
    // Static selection: use_alt only changes while the block is held idle.
    assign src_clk = use_alt ? alt_clk : norm_clk;
endmodule

// File: rtl/en_sync.sv
module en_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stage;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[0] <= 1'b0;
                else     stage[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= 1'b0;
                else     stage[i] <= stage[i-1];
            end
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/pow2_counter.sv
module pow2_counter
    import pow2div_pkg::*;
#(
    parameter int CODE_W = 2,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code,
    input  logic              en_s,
    output logic [CODE_W-1:0] code_q,
    output logic [CNT_W-1:0]  cnt,
    output div_state_t        st
);
    logic [CNT_W:0]   ratio;
    logic [CNT_W-1:0] last;
    logic [CNT_W-1:0] half;
    logic [CNT_W-1:0] cnt_nx;
    logic             wrap;
    logic             gate_eff;

    assign ratio    = {{CNT_W{1'b0}}, 1'b1} << code_q;
    assign last     = ratio[CNT_W-1:0] - {{(CNT_W-1){1'b0}}, 1'b1};
    assign half     = ratio[CNT_W:1];
    assign wrap     = (cnt == last);
    assign cnt_nx   = wrap ? '0 : cnt + {{(CNT_W-1){1'b0}}, 1'b1};
    // A new enable value is taken only where the low half begins.
    assign gate_eff = wrap ? en_s : st.gate;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= code;
            cnt    <= '0;
            st     <= '0;
        end else if (code != code_q) begin
            code_q   <= code;
            cnt      <= '0;
            st.pulse <= 1'b0;
        end else begin
            cnt      <= cnt_nx;
            st.gate  <= gate_eff;
            st.pulse <= gate_eff & (cnt_nx >= half);
        end
    end
endmodule

// File: rtl/pow2_clk_div.sv
module pow2_clk_div
    import pow2div_pkg::*;
#(
    parameter int CODE_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              osc_clk,
    input  logic              test_clk,
    input  logic              rst,
    input  logic              bypass,
    input  logic [CODE_W-1:0] div_code,
    input  logic              out_en,
    output logic              clk_out
);
    localparam int CNT_W = int'(count_width(CODE_W));

    logic              src_clk;
    logic              en_s;
    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  cnt;
    div_state_t        st;
    logic              gate;
    logic              pulse;
    logic              gate_fast;

    clk_src_sel u_sel (
        .norm_clk (osc_clk),
        .alt_clk  (test_clk),
        .use_alt  (bypass),
        .src_clk  (src_clk)
    );

    en_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (src_clk),
        .rst (rst),
        .d   (out_en),
        .q   (en_s)
    );

    pow2_counter #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_cnt (
        .clk    (src_clk),
        .rst    (rst),
        .code   (div_code),
        .en_s   (en_s),
        .code_q (code_q),
        .cnt    (cnt),
        .st     (st)
    );

    assign gate  = st.gate;
    assign pulse = st.pulse;

    // Full-rate path: the gate moves only while the source is low.
    always_ff @(negedge src_clk) begin
        if (rst) gate_fast <= 1'b0;
        else     gate_fast <= en_s;
    end

    assign clk_out = (code_q == '0) ? (src_clk & gate_fast) : pulse;
endmodule

// File: rtl/pow2_clk_div_chk.sv
module pow2_clk_div_chk #(
    parameter int CODE_W = 2,
    parameter int CNT_W  = 3
) (
    input logic              src_clk,
    input logic              rst,
    input logic [CODE_W-1:0] div_code,
    input logic [CODE_W-1:0] code_q,
    input logic [CNT_W-1:0]  cnt,
    input logic              gate,
    input logic              en_s,
    input logic              pulse
);
    logic [CNT_W:0]   r_c;
    logic [CNT_W-1:0] half_c;
    assign r_c    = {{CNT_W{1'b0}}, 1'b1} << code_q;
    assign half_c = r_c[CNT_W:1];

    // R6: a new code restarts the count with the output low.
    a_r6_code_restart: assert property (@(posedge src_clk) disable iff (rst)
        (div_code != code_q) |=> (cnt == '0 && !pulse));

    // R2: the divided output rises exactly at mid-period.
    a_r2_rise_mid_period: assert property (@(posedge src_clk) disable iff (rst)
        $rose(pulse) |-> (cnt == half_c));

    // R3: the applied enable moves only at a period boundary, from the synchroniser.
    a_r3_gate_at_boundary: assert property (@(posedge src_clk) disable iff (rst)
        !$stable(gate) |-> (cnt == '0 && gate == $past(en_s)));

    // R3: no output pulse starts without the applied enable.
    a_r3_rise_needs_gate: assert property (@(posedge src_clk) disable iff (rst)
        $rose(pulse) |-> gate);
endmodule

bind pow2_clk_div pow2_clk_div_chk #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_chk (
    .src_clk  (src_clk),
    .rst      (rst),
    .div_code (div_code),
    .code_q   (code_q),
    .cnt      (cnt),
    .gate     (gate),
    .en_s     (en_s),
    .pulse    (pulse)
);

// File: tb/sim_pow2_clk_div.sv
`timescale 1ns/1ps
module sim_pow2_clk_div;
    logic       clk = 1'b0;
    logic       tclk = 1'b0;
    logic       rst = 1'b1;
    logic       bypass = 1'b0;
    logic [1:0] code = 2'd0;
    logic       en = 1'b0;
    logic       clk_out;
    logic       src_b;

    int vectors = 0;
    int errors  = 0;
    int cyc     = 0;
    string cur_req = "R7";

    // Behavioural model state
    bit m_s1 = 0, m_s2 = 0, m_gate = 0, m_gate1 = 0, m_out = 0;
    int m_cnt = 0, m_code = 0;

    always #5 clk = ~clk;
    initial begin
        #3;
        forever #15 tclk = ~tclk;
    end
    assign src_b = bypass ? tclk : clk;

    pow2_clk_div u0 (
        .osc_clk  (clk),
        .test_clk (tclk),
        .rst      (rst),
        .bypass   (bypass),
        .div_code (code),
        .out_en   (en),
        .clk_out  (clk_out)
    );

    always @(posedge src_b) begin
        bit s2_old;
        int r;
        s2_old = m_s2;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_gate = 0; m_out = 0; m_cnt = 0; m_code = int'(code);
        end else begin
            m_s2 = m_s1;
            m_s1 = en;
            if (int'(code) != m_code) begin
                m_code = int'(code); m_cnt = 0; m_out = 0;
            end else begin
                r = 1 << m_code;
                if (m_cnt == r - 1) begin
                    m_cnt = 0; m_gate = s2_old;
                end else begin
                    m_cnt++;
                end
                m_out = m_gate && (m_cnt >= r / 2);
            end
        end
    end

    always @(negedge src_b) begin
        m_gate1 = rst ? 1'b0 : m_s2;
    end

    task automatic compare(input bit high_phase);
        bit exp;
        if (m_code == 0) exp = high_phase ? m_gate1 : 1'b0;
        else             exp = m_out;
        vectors++;
        if (clk_out !== exp) begin
            errors++;
            $display("FAIL %s t=%0t clk_out=%b expected=%b", cur_req, $time, clk_out, exp);
        end
    endtask

    always @(posedge src_b) begin
        #2;
        if (cyc >= 2) compare(1'b1);
    end
    always @(negedge src_b) begin
        #2;
        if (cyc >= 2) compare(1'b0);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge src_b);
        #3;
    endtask

    initial begin
        step(4);
        // R7: output held low in reset
        cur_req = "R7";
        vectors++;
        if (clk_out !== 1'b0) begin
            errors++;
            $display("FAIL R7 clk_out=%b expected=0", clk_out);
        end
        rst = 0;
        // R2 plain division with restarts (R6)
        cur_req = "R2";
        en = 1; code = 2'd1; step(40);
        code = 2'd2; cur_req = "R6"; step(6); cur_req = "R2"; step(40);
        code = 2'd3; step(80);
        // R3: enable toggles at every offset within a period
        cur_req = "R3";
        for (int off = 0; off < 8; off++) begin
            step(off + 1); en = 0;
            step(13 + off); en = 1;
            step(20);
        end
        code = 2'd1;
        for (int off = 0; off < 2; off++) begin
            step(off + 3); en = 0; step(7); en = 1; step(9);
        end
        // R1 / R4: full-rate path and its gating
        cur_req = "R1";
        code = 2'd0; step(20);
        cur_req = "R4";
        for (int k = 0; k < 4; k++) begin
            en = 0; step(5 + k); en = 1; step(6 + k);
        end
        // R6: code changes at assorted points
        cur_req = "R6";
        for (int k = 0; k < 8; k++) begin
            code = 2'(k % 4); step(3 + k);
            code = 2'((k + 2) % 4); step(11);
        end
        // R7: reset mid-run
        cur_req = "R7";
        code = 2'd3; step(13); rst = 1; step(3); rst = 0; step(30);
        // R5: bypass to the test clock
        cur_req = "R5";
        rst = 1; en = 0; step(2);
        bypass = 1; step(3);
        rst = 0; code = 2'd0; en = 1; step(20);
        code = 2'd2; step(24);
        code = 2'd1; en = 0; step(8); en = 1; step(16);
        rst = 1; en = 0; step(2);
        bypass = 0; step(3);
        rst = 0; en = 1; code = 2'd3; step(32);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule